// File: doc/BRIEF.md
# Timer status flag register

This block holds the sticky interrupt status flags of an advanced timer. The timer core hands it single-cycle strobes: a repetition-counter wrap, a software update request, a trigger-driven counter reload, per-channel compare matches and capture events, and a commutation event. It also receives the raw trigger and brake levels. Each event is latched into its own flag bit. The flag then stays set until software clears it over a simple register bus.

The update flag only takes the events that the update-disable and update-source controls allow through. Each capture channel also keeps an overcapture flag, which marks a capture that arrived while the previous one was still unread. In input mode, reading a channel's capture register clears that channel's capture flag. One interrupt line combines all flags through a 16-bit enable mask.

Every event input is sampled on the rising clock edge. The resulting flag is visible from that edge on. Reset is synchronous and active high.

Top module: `tmr_flag_regs`

## Requirements
- R1: The status register sits at bus address 0. Its bit layout is: bit 0 update, bits 1..4 compare/capture of channels 0..3, bit 5 commutation, bit 6 trigger, bit 7 brake, and bits 9..12 overcapture of channels 0..3. Bits 8 and 13..15 always read 0, and every flag is 0 after reset. A read (bus_rd with bus_addr 0) returns in bus_rdata one cycle later the flags held just before that edge. bus_rdata is 0 when no status read is made.
- R2: A write to address 0 clears each flag whose bus_wdata bit is 0 and leaves each flag whose bus_wdata bit is 1 unchanged. A write can never set a flag.
- R3: rep_wrap sets the update flag only while upd_dis is 0, whatever the value of upd_src_restrict.
- R4: sw_upd_gen and trg_reinit set the update flag only when both upd_dis and upd_src_restrict are 0.
- R5: A channel whose ch_input bit is 0 (output mode) sets its compare/capture flag on cmp_hit. In that mode its cap_evt is ignored.
- R6: A channel whose ch_input bit is 1 (input mode) sets its compare/capture flag on cap_evt and ignores cmp_hit. A cap_evt arriving while that flag was already 1 before the edge also sets the channel's overcapture flag.
- R7: A bus read at address 1+n clears channel n's compare/capture flag, but only in input mode. The overcapture flag is left unchanged.
- R8: When a hardware set and a clear of the same flag fall in one cycle, the flag ends up set.
- R9: With slave_gated 0, a rising edge of trg_lvl sets the trigger flag and a falling edge does not. With slave_gated 1, either edge sets it.
- R10: com_evt sets the commutation flag. The brake flag sets on every cycle in which brk_in equals brk_act_hi.
- R11: irq is registered. It goes high on the edge at which some flag that becomes or stays 1 has its irq_en bit (same bit position) at 1 at that edge, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_dis | input | 1 | Update-disable control |
| upd_src_restrict | input | 1 | Restricts update flag sources to the repetition wrap |
| rep_wrap | input | 1 | Repetition counter overflow/underflow strobe |
| sw_upd_gen | input | 1 | Software update-generate strobe |
| trg_reinit | input | 1 | Counter reinitialised by trigger strobe |
| ch_input | input | 4 | Per-channel mode, 1 = input capture |
| cmp_hit | input | 4 | Per-channel compare match strobes |
| cap_evt | input | 4 | Per-channel capture strobes |
| com_evt | input | 1 | Commutation event strobe |
| trg_lvl | input | 1 | Selected trigger input level |
| slave_gated | input | 1 | Slave controller is in gated mode |
| brk_in | input | 1 | Filtered brake input level |
| brk_act_hi | input | 1 | Active level of brake input |
| irq_en | input | 16 | Interrupt enable mask, bit-aligned with the flags |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read strobe |
| bus_addr | input | 3 | Bus word address |
| bus_wdata | input | 16 | Bus write data |
| bus_rdata | output | 16 | Registered read data |
| irq | output | 1 | Registered interrupt request |

## Verification
Assertions check the properties that hold on every cycle. Flags stay sticky when there is neither a write nor a capture read. The update flag stays low under update-disable, and also under the source restriction when no repetition wrap occurs. A set always wins over a clear, a capture on an already-set channel raises overcapture, a falling trigger edge outside gated mode raises no trigger flag, and irq tracks the masked flags. The bench scenarios alone show the things that need a chosen order of stimulus and readback. Among these are the exact bit layout seen through the bus, the write-one-keeps rule, and the mode-dependent clear on a capture-register read that leaves overcapture standing. Others are the brake polarity choice and the way irq follows changes of the enable mask.

// File: rtl/tmr_flag_pkg.sv
package tmr_flag_pkg;
  localparam int NUM_CH   = 4;
  localparam int REG_W    = 16;
  localparam int BIT_UPD  = 0;
  localparam int BIT_CC0  = 1;
  localparam int BIT_COM  = 5;
  localparam int BIT_TRG  = 6;
  localparam int BIT_BRK  = 7;
  localparam int BIT_OVC0 = 9;
  localparam int NUM_MISC = 4;

  typedef enum logic [1:0] {
    MISC_UPD = 2'd0,
    MISC_COM = 2'd1,
    MISC_TRG = 2'd2,
    MISC_BRK = 2'd3
  } misc_e;

  function automatic int misc_pos(input int idx);
    case (idx)
      0:       return BIT_UPD;
      1:       return BIT_COM;
      2:       return BIT_TRG;
      default: return BIT_BRK;
    endcase
  endfunction
endpackage

// File: rtl/tmr_upd_qual.sv
module tmr_upd_qual (
  input  logic upd_dis,
  input  logic upd_src_restrict,
  input  logic rep_wrap,
  input  logic sw_upd_gen,
  input  logic trg_reinit,
  output logic upd_set
);
  logic wrap_ok;
  logic soft_ok;

  always_comb begin
    wrap_ok = rep_wrap & ~upd_dis;
    soft_ok = (sw_upd_gen | trg_reinit) & ~upd_dis & ~upd_src_restrict;
    upd_set = wrap_ok | soft_ok;
  end
endmodule

// File: rtl/tmr_edge_det.sv
module tmr_edge_det (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  input  logic both_edges,
  output logic pulse
);
  logic lvl_q;

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= 1'b0;
    else     lvl_q <= lvl;
  end

  always_comb begin
    if (both_edges) pulse = lvl ^ lvl_q;
    else            pulse = lvl & ~lvl_q;
  end

  a_r9_no_fall_outside_gate: assert property (@(posedge clk) disable iff (rst)
    (!both_edges && $fell(lvl)) |-> !pulse)
    else $error("R9 falling trigger edge produced a pulse outside gated mode");
endmodule

// File: rtl/tmr_sticky_flag.sv
module tmr_sticky_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_q,
  output logic flag_nxt
);
  always_comb flag_nxt = set_i | (flag_q & ~clr_i);

  always_ff @(posedge clk) begin
    if (rst) flag_q <= 1'b0;
    else     flag_q <= flag_nxt;
  end

  a_r8_set_beats_clear: assert property (@(posedge clk) disable iff (rst)
    set_i |=> flag_q)
    else $error("R8 set lost against clear");
endmodule

// File: rtl/tmr_chan_flag.sv
module tmr_chan_flag (
  input  logic clk,
  input  logic rst,
  input  logic is_input,
  input  logic cmp_match,
  input  logic cap_strobe,
  input  logic cap_read,
  input  logic clr_cc,
  input  logic clr_ovc,
  output logic cc_q,
  output logic cc_nxt,
  output logic ovc_q,
  output logic ovc_nxt
);
  logic cc_set;
  logic cc_clr;
  logic ovc_set;

  always_comb begin
    cc_set  = is_input ? cap_strobe : cmp_match;
    cc_clr  = clr_cc | (is_input & cap_read);
    ovc_set = is_input & cap_strobe & cc_q;
    cc_nxt  = cc_set | (cc_q & ~cc_clr);
    ovc_nxt = ovc_set | (ovc_q & ~clr_ovc);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cc_q  <= 1'b0;
      ovc_q <= 1'b0;
    end else begin
      cc_q  <= cc_nxt;
      ovc_q <= ovc_nxt;
    end
  end

  a_r6_overcapture: assert property (@(posedge clk) disable iff (rst)
    (is_input && cap_strobe && cc_q) |=> ovc_q)
    else $error("R6 overcapture not flagged");

  a_r8_chan_set_wins: assert property (@(posedge clk) disable iff (rst)
    ((is_input && cap_strobe) || (!is_input && cmp_match)) |=> cc_q)
    else $error("R8 channel set lost");

  a_r7_read_keeps_ovc: assert property (@(posedge clk) disable iff (rst)
    (ovc_q && !clr_ovc) |=> ovc_q)
    else $error("R7 overcapture dropped without a write clear");
endmodule

// File: rtl/tmr_flag_regs.sv
module tmr_flag_regs
  import tmr_flag_pkg::*;
#(
  parameter int ADDR_W    = 3,
  parameter int STAT_ADDR = 0,
  parameter int CAP_BASE  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd_dis,
  input  logic              upd_src_restrict,
  input  logic              rep_wrap,
  input  logic              sw_upd_gen,
  input  logic              trg_reinit,
  input  logic [NUM_CH-1:0] ch_input,
  input  logic [NUM_CH-1:0] cmp_hit,
  input  logic [NUM_CH-1:0] cap_evt,
  input  logic              com_evt,
  input  logic              trg_lvl,
  input  logic              slave_gated,
  input  logic              brk_in,
  input  logic              brk_act_hi,
  input  logic [REG_W-1:0]  irq_en,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] STAT_SEL = ADDR_W'(STAT_ADDR);

  logic              stat_hit_wr;
  logic              stat_hit_rd;
  logic [REG_W-1:0]  clr_mask;
  logic [NUM_CH-1:0] cap_rd_hit;
  logic [NUM_MISC-1:0] misc_set;
  logic [NUM_MISC-1:0] misc_q;
  logic [NUM_MISC-1:0] misc_nxt;
  logic [NUM_CH-1:0] cc_q, cc_nxt, ovc_q, ovc_nxt;
  logic [REG_W-1:0]  stat_q;
  logic [REG_W-1:0]  stat_nxt;
  logic              upd_set;
  logic              trg_pulse;
  logic              brk_active;
  logic [REG_W-1:0]  rdata_q;
  logic              irq_q;
  logic              wdata_unused;

  always_comb begin
    stat_hit_wr = bus_wr & (bus_addr == STAT_SEL);
    stat_hit_rd = bus_rd & (bus_addr == STAT_SEL);
    clr_mask    = stat_hit_wr ? ~bus_wdata : '0;
    brk_active  = (brk_in == brk_act_hi);
  end

  assign wdata_unused = ^{bus_wdata[REG_W-1:BIT_OVC0+NUM_CH], bus_wdata[BIT_BRK+1]};

  tmr_upd_qual u_upd_qual (
    .upd_dis          (upd_dis),
    .upd_src_restrict (upd_src_restrict),
    .rep_wrap         (rep_wrap),
    .sw_upd_gen       (sw_upd_gen),
    .trg_reinit       (trg_reinit),
    .upd_set          (upd_set)
  );

  tmr_edge_det u_trg_edge (
    .clk        (clk),
    .rst        (rst),
    .lvl        (trg_lvl),
    .both_edges (slave_gated),
    .pulse      (trg_pulse)
  );

  always_comb begin
    misc_set[MISC_UPD] = upd_set;
    misc_set[MISC_COM] = com_evt;
    misc_set[MISC_TRG] = trg_pulse;
    misc_set[MISC_BRK] = brk_active;
  end

  for (genvar m = 0; m < NUM_MISC; m++) begin : g_misc
    tmr_sticky_flag u_flag (
      .clk      (clk),
      .rst      (rst),
      .set_i    (misc_set[m]),
      .clr_i    (clr_mask[misc_pos(m)]),
      .flag_q   (misc_q[m]),
      .flag_nxt (misc_nxt[m])
    );
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    assign cap_rd_hit[c] = bus_rd & (bus_addr == ADDR_W'(CAP_BASE + c));

    tmr_chan_flag u_chan (
      .clk        (clk),
      .rst        (rst),
      .is_input   (ch_input[c]),
      .cmp_match  (cmp_hit[c]),
      .cap_strobe (cap_evt[c]),
      .cap_read   (cap_rd_hit[c]),
      .clr_cc     (clr_mask[BIT_CC0 + c]),
      .clr_ovc    (clr_mask[BIT_OVC0 + c]),
      .cc_q       (cc_q[c]),
      .cc_nxt     (cc_nxt[c]),
      .ovc_q      (ovc_q[c]),
      .ovc_nxt    (ovc_nxt[c])
    );
  end

  always_comb begin
    stat_q   = '0;
    stat_nxt = '0;
    for (int m = 0; m < NUM_MISC; m++) begin
      stat_q[misc_pos(m)]   = misc_q[m];
      stat_nxt[misc_pos(m)] = misc_nxt[m];
    end
    for (int c = 0; c < NUM_CH; c++) begin
      stat_q[BIT_CC0 + c]    = cc_q[c];
      stat_nxt[BIT_CC0 + c]  = cc_nxt[c];
      stat_q[BIT_OVC0 + c]   = ovc_q[c];
      stat_nxt[BIT_OVC0 + c] = ovc_nxt[c];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      rdata_q <= stat_hit_rd ? stat_q : '0;
      irq_q   <= |(stat_nxt & irq_en);
    end
  end

  assign bus_rdata = rdata_q;
  assign irq       = irq_q;

  a_r2_sticky: assert property (@(posedge clk) disable iff (rst)
    (!bus_wr && !bus_rd) |=> ((stat_q & $past(stat_q)) == $past(stat_q)))
    else $error("R2 flag dropped without a clear");

  a_r3_upd_blocked: assert property (@(posedge clk) disable iff (rst)
    (upd_dis && !stat_q[BIT_UPD]) |=> !stat_q[BIT_UPD])
    else $error("R3 update flag set while disabled");

  a_r4_src_restrict: assert property (@(posedge clk) disable iff (rst)
    (upd_src_restrict && !rep_wrap && !stat_q[BIT_UPD]) |=> !stat_q[BIT_UPD])
    else $error("R4 update flag set by a restricted source");

  a_r11_irq_mask: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == |(stat_q & $past(irq_en))))
    else $error("R11 irq does not match masked flags");

  a_r1_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    $past(stat_hit_rd) |-> (bus_rdata[BIT_BRK+1] == 1'b0 &&
                            bus_rdata[REG_W-1:BIT_OVC0+NUM_CH] == '0))
    else $error("R1 reserved bit read as 1");
endmodule

// File: tb/tmr_flag_regs_test.sv
`timescale 1ns/1ps
module tmr_flag_regs_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic upd_dis = 0, upd_src_restrict = 0, rep_wrap = 0, sw_upd_gen = 0, trg_reinit = 0;
  logic [3:0] ch_input = '0, cmp_hit = '0, cap_evt = '0;
  logic com_evt = 0, trg_lvl = 0, slave_gated = 0, brk_in = 0, brk_act_hi = 1;
  logic [15:0] irq_en = '0;
  logic bus_wr = 0, bus_rd = 0;
  logic [2:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic irq;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  typedef struct { logic [15:0] exp; string tag; } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;

  tmr_flag_regs uut (
    .clk(clk), .rst(rst), .upd_dis(upd_dis), .upd_src_restrict(upd_src_restrict),
    .rep_wrap(rep_wrap), .sw_upd_gen(sw_upd_gen), .trg_reinit(trg_reinit),
    .ch_input(ch_input), .cmp_hit(cmp_hit), .cap_evt(cap_evt), .com_evt(com_evt),
    .trg_lvl(trg_lvl), .slave_gated(slave_gated), .brk_in(brk_in), .brk_act_hi(brk_act_hi),
    .irq_en(irq_en), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  // monitor: pops one expected item per status read
  logic rd_seen = 0;
  always @(posedge clk) rd_seen <= bus_rd && (bus_addr == 3'd0);
  always @(negedge clk) begin : mon
    exp_t e;
    if (rd_seen) begin
      if (sb.size() == 0) check("scoreboard underflow", 16'hxxxx, 16'h0);
      else begin
        e = sb.pop_front();
        check(e.tag, bus_rdata, e.exp);
      end
    end
  end

  task automatic rd_stat(input logic [15:0] exp, input string tag);
    @(negedge clk);
    bus_rd = 1; bus_addr = 3'd0;
    sb.push_back('{exp: exp, tag: tag});
    @(negedge clk);
    bus_rd = 0;
  endtask

  task automatic wr_stat(input logic [15:0] data);
    @(negedge clk);
    bus_wr = 1; bus_addr = 3'd0; bus_wdata = data;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic cap_read(input int ch);
    @(negedge clk);
    bus_rd = 1; bus_addr = 3'(1 + ch);
    @(negedge clk);
    bus_rd = 0;
  endtask

  // kind: 0 wrap, 1 sw update, 2 trigger reload, 3 compare, 4 capture, 5 commutation
  task automatic fire(input int kind, input int ch);
    @(negedge clk);
    case (kind)
      0: rep_wrap = 1;
      1: sw_upd_gen = 1;
      2: trg_reinit = 1;
      3: cmp_hit[ch] = 1;
      4: cap_evt[ch] = 1;
      default: com_evt = 1;
    endcase
    @(negedge clk);
    rep_wrap = 0; sw_upd_gen = 0; trg_reinit = 0; cmp_hit = '0; cap_evt = '0; com_evt = 0;
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    @(negedge clk);
    check(tag, {15'd0, irq}, {15'd0, exp});
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got hang expected completion");
    report();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    // R1 reset state
    rd_stat(16'h0000, "R1 reset value");
    chk_irq(1'b0, "R11 irq after reset");

    // R3 / R2
    fire(0, 0);
    rd_stat(16'h0001, "R3 wrap sets update");
    wr_stat(16'hFFFF);
    rd_stat(16'h0001, "R2 write one keeps");
    wr_stat(16'hFFFE);
    rd_stat(16'h0000, "R2 write zero clears");

    // R3 / R4 disabled
    upd_dis = 1;
    fire(0, 0); fire(1, 0); fire(2, 0);
    rd_stat(16'h0000, "R3 R4 update disabled");
    upd_dis = 0; upd_src_restrict = 1;
    fire(1, 0); fire(2, 0);
    rd_stat(16'h0000, "R4 source restricted");
    fire(0, 0);
    rd_stat(16'h0001, "R3 wrap under restriction");
    wr_stat(16'h0000);
    upd_src_restrict = 0;
    fire(1, 0);
    rd_stat(16'h0001, "R4 sw update");
    wr_stat(16'h0000);
    fire(2, 0);
    rd_stat(16'h0001, "R4 trigger reload");
    wr_stat(16'h0000);

    // R5 / R6 / R7 channels: ch0 input, others output
    ch_input = 4'b0001;
    fire(3, 1);
    rd_stat(16'h0004, "R5 compare match ch1");
    fire(4, 1);
    rd_stat(16'h0004, "R5 capture ignored in output mode");
    wr_stat(16'h0000);
    fire(3, 0);
    rd_stat(16'h0000, "R6 match ignored in input mode");
    fire(4, 0);
    rd_stat(16'h0002, "R6 capture sets ch0");
    fire(4, 0);
    rd_stat(16'h0202, "R6 overcapture ch0");
    cap_read(0);
    rd_stat(16'h0200, "R7 capture read clears cc keeps ovc");
    wr_stat(16'h0000);
    rd_stat(16'h0000, "R2 clear all");
    fire(3, 2);
    cap_read(2);
    rd_stat(16'h0008, "R7 read in output mode no clear");

    // R8 set wins
    @(negedge clk);
    cmp_hit[2] = 1; bus_wr = 1; bus_addr = 3'd0; bus_wdata = 16'h0000;
    @(negedge clk);
    cmp_hit = '0; bus_wr = 0;
    rd_stat(16'h0008, "R8 set beats clear");
    wr_stat(16'h0000);
    rd_stat(16'h0000, "R8 clear afterwards");

    // R9 trigger
    @(negedge clk); trg_lvl = 1;
    rd_stat(16'h0040, "R9 rising edge");
    wr_stat(16'h0000);
    @(negedge clk); trg_lvl = 0;
    rd_stat(16'h0000, "R9 falling edge ignored");
    @(negedge clk); slave_gated = 1;
    @(negedge clk); trg_lvl = 1;
    rd_stat(16'h0040, "R9 gated rising");
    wr_stat(16'h0000);
    @(negedge clk); trg_lvl = 0;
    rd_stat(16'h0040, "R9 gated falling");
    wr_stat(16'h0000);

    // R10 commutation and brake
    fire(5, 0);
    rd_stat(16'h0020, "R10 commutation");
    wr_stat(16'h0000);
    @(negedge clk); brk_in = 1; brk_act_hi = 0;
    rd_stat(16'h0000, "R10 brake inactive level");
    @(negedge clk); brk_in = 0;
    @(negedge clk); brk_in = 1;
    rd_stat(16'h0080, "R10 brake active low");
    wr_stat(16'h0000);
    rd_stat(16'h0000, "R10 brake cleared");

    // R11 interrupt mask
    fire(5, 0);
    chk_irq(1'b0, "R11 masked flag");
    irq_en = 16'h0020;
    chk_irq(1'b1, "R11 enabled flag");
    irq_en = 16'h0001;
    chk_irq(1'b0, "R11 other bit enabled");
    irq_en = 16'h0200;
    wr_stat(16'h0000);
    fire(4, 0); fire(4, 0);
    cap_read(0);
    chk_irq(1'b1, "R11 overcapture drives irq");
    wr_stat(16'h0000);
    chk_irq(1'b0, "R11 irq drops after clear");
    rd_stat(16'h0000, "R1 final state");

    repeat (3) @(negedge clk);
    if (sb.size() != 0) check("scoreboard drained", 16'(sb.size()), 16'h0);
    report();
  end
endmodule